// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This controller turns internal memory requests into bus cycles on a shared address/data bus. A request carries an address, write data, a read/write flag, a byte/word flag and an instruction-fetch flag. The controller accepts a request only while it is idle. Each bus cycle has three phases. The address phase drives the address on the shared bus and strobes the external latch. The data phase asserts a read or write strobe and can be stretched by wait states. The hold phase releases the strobes and keeps write data stable. When the controller finishes, it returns read data together with a one-cycle completion pulse.

Configuration inputs set several options. Two bits set the bus-width policy: a fixed 8-bit bus, a fixed 16-bit bus, or a width chosen per request from a pin. One bit picks how the byte lanes are signalled: separate low/high write strobes, or one write strobe plus an active-low high-byte enable. Another bit makes the latch output either a short positive address-latch pulse or an active-low address-valid level that can act as a chip select. A small field caps the number of wait states that the ready input can add.

A word access on an 8-bit bus becomes two byte cycles. The combination with both width bits clear is illegal: it is flagged, and the bus is then run as 8-bit.

Top module: `extBusCtrl`

## Requirements
- R1: The width policy is read from the bits {cfgWidthA, cfgWidthB}. With 2'b11, widthIn is sampled when the request is accepted: low gives 8-bit cycles, high gives 16-bit cycles. 2'b01 always gives 8-bit cycles. 2'b10 always gives 16-bit cycles.
- R2: With cfgWidthA = cfgWidthB = 0, cfgError is high and the request runs with 8-bit cycles. With any other setting, cfgError is low.
- R3: A word access ignores address bit 0. On an 8-bit bus it runs as two byte cycles: first at the even address carrying the low byte, then at the odd address carrying the high byte. On an 8-bit cycle the byte being written appears on both halves of busAdOut.
- R4: On a 16-bit cycle the byte lanes are encoded by the address bit A0 and the high-byte enable (active low). An even byte has A0 = 0 with the enable high. An odd byte has A0 = 1 with the enable low. A word has A0 = 0 with the enable low. On an 8-bit cycle the enable stays high and data uses busAdIn[7:0]. A byte read returns its byte zero-extended in rdData[7:0].
- R5: With cfgStrobeMode = 0, wrLowN is low during the data phase of writes that use the low lane: 16-bit cycles with A0 = 0, and every 8-bit write cycle. wrHighN is low during the data phase of 16-bit writes that use the high lane: odd bytes and words.
- R6: With cfgStrobeMode = 1, wrLowN is low during the data phase of every write. wrHighN carries the active-low high-byte enable from the address phase through the hold phase.
- R7: Each byte cycle has one address phase, one or more data-phase cycles and one hold cycle. In the address phase busAdOut carries the address with busAdOe high. rdN is low only in the data phase of reads. With cfgAdvMode = 0, aleAdv is high for exactly the address-phase cycle.
- R8: With cfgAdvMode = 1, aleAdv is low during the address and data phases. It is high during the hold phase and while idle.
- R9: The data phase lasts one cycle plus one extra cycle for each clock edge that finds readyIn low while fewer than cfgMaxWait waits have been added. With cfgMaxWait = 0 every data phase lasts one cycle.
- R10: fetchOut is high through every phase of read cycles whose request has the fetch flag set. It is low during writes and while idle.
- R11: reqReady is high only while idle. done pulses for one cycle in the hold phase of the final byte cycle, and rdData then holds the complete read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqAddr | input | AD_W | Byte address |
| reqWdata | input | AD_W | Write data (a byte write uses bits 7:0) |
| reqReady | output | 1 | Controller idle, request accepted |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | AD_W | Read result |
| cfgWidthA | input | 1 | Width policy bit A |
| cfgWidthB | input | 1 | Width policy bit B |
| cfgStrobeMode | input | 1 | 0 = low/high write strobes, 1 = write plus high enable |
| cfgAdvMode | input | 1 | 0 = latch pulse, 1 = address-valid level |
| cfgMaxWait | input | WAIT_W | Maximum wait states per byte cycle |
| cfgError | output | 1 | Illegal width policy selected |
| readyIn | input | 1 | External ready |
| widthIn | input | 1 | External bus-width select |
| busAdIn | input | AD_W | Shared bus, read direction |
| busAdOut | output | AD_W | Shared bus, drive direction |
| busAdOe | output | 1 | Shared bus output enable |
| aleAdv | output | 1 | Address latch pulse or address-valid level |
| rdN | output | 1 | Read strobe, active low |
| wrLowN | output | 1 | Low-lane write strobe or plain write strobe |
| wrHighN | output | 1 | High-lane write strobe or high-byte enable |
| fetchOut | output | 1 | Instruction-fetch indicator |

## Verification
The bench uses the default AD_W = 16 and WAIT_W = 3, which allow wait caps up to seven. It drives caps of zero, two and three against ready-low stretches both shorter and longer than the cap, so a stretched phase, a truncated phase and a ready input that is ignored are all observed. With a 16-bit shared bus, every lane pattern (even byte, odd byte, word) and the two-cycle word split can be seen at the ports under all three legal width policies and the illegal one.

// File: rtl/extBusPkg.sv
package extBusPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_HOLD
  } busState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // latch a new request
    logic addrPhase;   // drive address
    logic dataPhase;   // strobe phase
    logic holdPhase;   // strobes released
    logic isWrite;
    logic wide;        // 16-bit cycle
    logic word;        // word access
    logic secondByte;  // second half of a split word
    logic curA0;       // address bit 0 of this byte cycle
    logic capture;     // sample read data this cycle
  } busCtl_t;

endpackage

// File: rtl/extBusFsm.sv
module extBusFsm
  import extBusPkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              reqFetch,
  input  logic              reqA0,
  input  logic              readyIn,
  input  logic              widthIn,
  input  logic              cfgWidthA,
  input  logic              cfgWidthB,
  input  logic              cfgStrobeMode,
  input  logic              cfgAdvMode,
  input  logic [WAIT_W-1:0] cfgMaxWait,
  output logic              reqReady,
  output logic              done,
  output logic              cfgError,
  output logic              aleAdv,
  output logic              rdN,
  output logic              wrLowN,
  output logic              wrHighN,
  output logic              fetchOut,
  output busCtl_t           ctl
);

  busState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic              wrR, wordR, fetchR, a0R, wideR, byteIdx;
  logic              accept, widthSel, split, lastByte, stayWait;
  logic              curA0, laneLow, laneHigh, inCycle;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign split    = wordR && !wideR;
  assign lastByte = !split || byteIdx;
  assign stayWait = !readyIn && (waitCnt < cfgMaxWait);
  assign curA0    = wordR ? byteIdx : a0R;
  assign laneLow  = !wideR || !curA0;
  assign laneHigh = wideR && (wordR || curA0);
  assign cfgError = !cfgWidthA && !cfgWidthB;

  // width policy: pin-driven, fixed 16, otherwise 8 (illegal falls here)
  always_comb begin
    unique case ({cfgWidthA, cfgWidthB})
      2'b11:   widthSel = widthIn;
      2'b10:   widthSel = 1'b1;
      default: widthSel = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      wrR     <= 1'b0;
      wordR   <= 1'b0;
      fetchR  <= 1'b0;
      a0R     <= 1'b0;
      wideR   <= 1'b0;
      byteIdx <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_ADDR;
          wrR     <= reqWrite;
          wordR   <= reqWord;
          fetchR  <= reqFetch;
          a0R     <= reqA0;
          wideR   <= widthSel;
          byteIdx <= 1'b0;
        end
        ST_ADDR: begin
          state   <= ST_DATA;
          waitCnt <= '0;
        end
        ST_DATA: begin
          if (stayWait) waitCnt <= waitCnt + 1'b1;
          else          state   <= ST_HOLD;
        end
        ST_HOLD: begin
          if (lastByte) state <= ST_IDLE;
          else begin
            state   <= ST_ADDR;
            byteIdx <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load       = accept;
    ctl.addrPhase  = (state == ST_ADDR);
    ctl.dataPhase  = (state == ST_DATA);
    ctl.holdPhase  = (state == ST_HOLD);
    ctl.isWrite    = wrR;
    ctl.wide       = wideR;
    ctl.word       = wordR;
    ctl.secondByte = byteIdx;
    ctl.curA0      = curA0;
    ctl.capture    = (state == ST_DATA) && !stayWait && !wrR;
  end

  assign inCycle  = ctl.addrPhase || ctl.dataPhase || ctl.holdPhase;
  assign reqReady = (state == ST_IDLE);
  assign done     = ctl.holdPhase && lastByte;
  assign aleAdv   = cfgAdvMode ? !(ctl.addrPhase || ctl.dataPhase) : ctl.addrPhase;
  assign rdN      = !(ctl.dataPhase && !wrR);
  assign fetchOut = inCycle && fetchR && !wrR;

  always_comb begin
    if (cfgStrobeMode) begin
      wrLowN  = !(ctl.dataPhase && wrR);
      wrHighN = !(inCycle && laneHigh);
    end else begin
      wrLowN  = !(ctl.dataPhase && wrR && laneLow);
      wrHighN = !(ctl.dataPhase && wrR && laneHigh);
    end
  end

endmodule

// File: rtl/extBusData.sv
module extBusData
  import extBusPkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  busCtl_t         ctl,
  input  logic [AD_W-1:0] reqAddr,
  input  logic [AD_W-1:0] reqWdata,
  input  logic [AD_W-1:0] busAdIn,
  output logic [AD_W-1:0] busAdOut,
  output logic            busAdOe,
  output logic [AD_W-1:0] rdData
);

  localparam int BYTE_W = AD_W / 2;

  logic [AD_W-1:0]   addrR, wdR, rdR;
  logic [BYTE_W-1:0] laneLo, laneHi, wrByte;

  assign laneLo = busAdIn[BYTE_W-1:0];
  assign laneHi = busAdIn[AD_W-1:BYTE_W];
  assign wrByte = ctl.secondByte ? wdR[AD_W-1:BYTE_W] : wdR[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR <= '0;
      wdR   <= '0;
      rdR   <= '0;
    end else if (ctl.load) begin
      addrR <= reqAddr;
      wdR   <= reqWdata;
      rdR   <= '0;
    end else if (ctl.capture) begin
      if (ctl.wide && ctl.word)  rdR <= busAdIn;
      else if (ctl.wide)         rdR <= {{BYTE_W{1'b0}}, (ctl.curA0 ? laneHi : laneLo)};
      else if (ctl.secondByte)   rdR[AD_W-1:BYTE_W] <= laneLo;
      else                       rdR[BYTE_W-1:0]    <= laneLo;
    end
  end

  always_comb begin
    busAdOut = '0;
    if (ctl.addrPhase)
      busAdOut = {addrR[AD_W-1:1], ctl.curA0};
    else if ((ctl.dataPhase || ctl.holdPhase) && ctl.isWrite)
      busAdOut = (ctl.wide && ctl.word) ? wdR : {wrByte, wrByte};
  end

  assign busAdOe = ctl.addrPhase || ((ctl.dataPhase || ctl.holdPhase) && ctl.isWrite);
  assign rdData  = rdR;

endmodule

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
#(
  parameter int AD_W   = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              reqFetch,
  input  logic [AD_W-1:0]   reqAddr,
  input  logic [AD_W-1:0]   reqWdata,
  output logic              reqReady,
  output logic              done,
  output logic [AD_W-1:0]   rdData,
  input  logic              cfgWidthA,
  input  logic              cfgWidthB,
  input  logic              cfgStrobeMode,
  input  logic              cfgAdvMode,
  input  logic [WAIT_W-1:0] cfgMaxWait,
  output logic              cfgError,
  input  logic              readyIn,
  input  logic              widthIn,
  input  logic [AD_W-1:0]   busAdIn,
  output logic [AD_W-1:0]   busAdOut,
  output logic              busAdOe,
  output logic              aleAdv,
  output logic              rdN,
  output logic              wrLowN,
  output logic              wrHighN,
  output logic              fetchOut
);

  busCtl_t ctl;

  extBusFsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqWrite      (reqWrite),
    .reqWord       (reqWord),
    .reqFetch      (reqFetch),
    .reqA0         (reqAddr[0]),
    .readyIn       (readyIn),
    .widthIn       (widthIn),
    .cfgWidthA     (cfgWidthA),
    .cfgWidthB     (cfgWidthB),
    .cfgStrobeMode (cfgStrobeMode),
    .cfgAdvMode    (cfgAdvMode),
    .cfgMaxWait    (cfgMaxWait),
    .reqReady      (reqReady),
    .done          (done),
    .cfgError      (cfgError),
    .aleAdv        (aleAdv),
    .rdN           (rdN),
    .wrLowN        (wrLowN),
    .wrHighN       (wrHighN),
    .fetchOut      (fetchOut),
    .ctl           (ctl)
  );

  extBusData #(.AD_W(AD_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busAdIn  (busAdIn),
    .busAdOut (busAdOut),
    .busAdOe  (busAdOe),
    .rdData   (rdData)
  );

endmodule

// File: rtl/extBusCtrlChecker.sv
module extBusCtrlChecker #(
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgAdvMode,
  input logic [WAIT_W-1:0] cfgMaxWait,
  input logic              reqReady,
  input logic              done,
  input logic              aleAdv,
  input logic              rdN,
  input logic              wrLowN,
  input logic              fetchOut,
  input logic              busAdOe
);

  logic [WAIT_W:0] rdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdRun <= '0;
    else if (!rdN) rdRun <= rdRun + 1'b1;
    else           rdRun <= '0;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrLowN)); // R7

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgAdvMode && aleAdv) |=> !aleAdv); // R7

  AST_ADV_END: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAdvMode && done) |-> aleAdv); // R8

  AST_STROBE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (rdRun <= {1'b0, cfgMaxWait})); // R9

  AST_FETCH_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    fetchOut |-> wrLowN); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busAdOe && rdN)); // R11

endmodule

bind extBusCtrl extBusCtrlChecker #(.WAIT_W(WAIT_W)) u_chk (.*);

// File: tb/extBusCtrl_bench.sv
module extBusCtrl_bench;

  localparam int AD_W   = 16;
  localparam int WAIT_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0, reqFetch = 1'b0;
  logic [AD_W-1:0]   reqAddr = '0, reqWdata = '0;
  logic              reqReady, done, cfgError;
  logic [AD_W-1:0]   rdData;
  logic              cfgWidthA = 1'b1, cfgWidthB = 1'b0, cfgStrobeMode = 1'b0, cfgAdvMode = 1'b0;
  logic [WAIT_W-1:0] cfgMaxWait = '0;
  logic              readyIn = 1'b1, widthIn = 1'b0;
  logic [AD_W-1:0]   busAdIn, busAdOut;
  logic              busAdOe, aleAdv, rdN, wrLowN, wrHighN, fetchOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  extBusCtrl #(.AD_W(AD_W), .WAIT_W(WAIT_W)) u_extBusCtrl (.*);

  // external memory model: byte at address a reads as a[7:0]^5A
  logic [15:0] lat = '0;
  logic        curW16 = 1'b0;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign busAdIn = curW16 ? {memByte(lat | 16'h0001), memByte(lat & 16'hFFFE)}
                          : {8'hEE, memByte(lat)};

  typedef struct packed {
    logic        wr, word, fetch;
    logic [15:0] addr, wdata;
    logic        wA, wB, wPin, sMode, adv;
    logic [2:0]  maxW, rdyLow;
    logic [1:0]  eCyc;
    logic [15:0] eAddr;
    logic        eBhe;
    logic [1:0]  eWl, eWh;
    logic [3:0]  eStb;
    logic        eFetch;
    logic [15:0] eWd, eRd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R1 R4 R10 fixed 16-bit word fetch
    '{1'b0,1'b1,1'b1,16'h1234,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h1234,1'b1,2'd0,2'd0,4'd1,1'b1,16'h0000,16'h6F6E},
    // R4 R6 odd byte read
    '{1'b0,1'b0,1'b0,16'h1235,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h1235,1'b1,2'd0,2'd0,4'd1,1'b0,16'h0000,16'h006F},
    // R4 even byte read
    '{1'b0,1'b0,1'b0,16'h1234,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h1234,1'b0,2'd0,2'd0,4'd1,1'b0,16'h0000,16'h006E},
    // R5 word write, both lanes
    '{1'b1,1'b1,1'b0,16'h4000,16'hBEEF,1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0, 2'd1,16'h4000,1'b0,2'd1,2'd1,4'd1,1'b0,16'hBEEF,16'h0000},
    // R5 odd byte write, high lane only
    '{1'b1,1'b0,1'b0,16'h4001,16'h00A5,1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0, 2'd1,16'h4001,1'b0,2'd0,2'd1,4'd1,1'b0,16'hA5A5,16'h0000},
    // R5 even byte write, low lane only
    '{1'b1,1'b0,1'b0,16'h4002,16'h003C,1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0, 2'd1,16'h4002,1'b0,2'd1,2'd0,4'd1,1'b0,16'h3C3C,16'h0000},
    // R1 R3 fixed 8-bit word write split
    '{1'b1,1'b1,1'b0,16'h5000,16'h1122,1'b0,1'b1,1'b0,1'b0,1'b0,3'd3,3'd0, 2'd2,16'h5000,1'b0,2'd2,2'd0,4'd2,1'b0,16'h2222,16'h0000},
    // R1 R3 pin-selected 8-bit word read split
    '{1'b0,1'b1,1'b0,16'h1234,16'h0000,1'b1,1'b1,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd2,16'h1234,1'b0,2'd0,2'd0,4'd2,1'b0,16'h0000,16'h6F6E},
    // R1 pin-selected 16-bit word read
    '{1'b0,1'b1,1'b0,16'h1234,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h1234,1'b1,2'd0,2'd0,4'd1,1'b0,16'h0000,16'h6F6E},
    // R2 illegal policy runs 8-bit
    '{1'b0,1'b1,1'b0,16'h1234,16'h0000,1'b0,1'b0,1'b1,1'b1,1'b0,3'd3,3'd0, 2'd2,16'h1234,1'b0,2'd0,2'd0,4'd2,1'b0,16'h0000,16'h6F6E},
    // R9 two waits within cap of three
    '{1'b0,1'b0,1'b0,16'h2001,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd2, 2'd1,16'h2001,1'b1,2'd0,2'd0,4'd3,1'b0,16'h0000,16'h005B},
    // R9 ready held low beyond cap of two
    '{1'b0,1'b0,1'b0,16'h2001,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd2,3'd5, 2'd1,16'h2001,1'b1,2'd0,2'd0,4'd3,1'b0,16'h0000,16'h005B},
    // R9 cap zero ignores ready
    '{1'b0,1'b0,1'b0,16'h2001,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd0,3'd4, 2'd1,16'h2001,1'b1,2'd0,2'd0,4'd1,1'b0,16'h0000,16'h005B},
    // R6 plain write plus high enable, odd byte
    '{1'b1,1'b0,1'b0,16'h4001,16'h00A5,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h4001,1'b1,2'd1,2'd0,4'd1,1'b0,16'hA5A5,16'h0000},
    // R8 R10 address-valid mode fetch
    '{1'b0,1'b1,1'b1,16'h1234,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b1,3'd3,3'd0, 2'd1,16'h1234,1'b1,2'd0,2'd0,4'd1,1'b1,16'h0000,16'h6F6E},
    // R6 word write with high enable
    '{1'b1,1'b1,1'b0,16'h4000,16'hBEEF,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h4000,1'b1,2'd1,2'd0,4'd1,1'b0,16'hBEEF,16'h0000},
    // R10 fetch flag on a write has no effect
    '{1'b1,1'b0,1'b1,16'h4002,16'h003C,1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0, 2'd1,16'h4002,1'b0,2'd1,2'd0,4'd1,1'b0,16'h3C3C,16'h0000},
    // R3 word at odd address uses even address
    '{1'b0,1'b1,1'b0,16'h1235,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0,3'd3,3'd0, 2'd1,16'h1234,1'b1,2'd0,2'd0,4'd1,1'b0,16'h0000,16'h6F6E}
  };

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic runVec(input int idx, input vec_t v);
    int nCyc = 0, wl = 0, wh = 0, stb = 0, stbK = 0;
    logic [15:0] addr1 = '0, wd1 = '0, rd = '0;
    logic bhe1 = 1'b0, fetchSeen = 1'b0, busy = 1'b0, gotDone = 1'b0, firstStb = 1'b1;
    logic isStb, isAddr;
    @(negedge clk);
    cfgWidthA = v.wA; cfgWidthB = v.wB; widthIn = v.wPin;
    cfgStrobeMode = v.sMode; cfgAdvMode = v.adv; cfgMaxWait = v.maxW;
    curW16 = (v.wA && v.wB) ? v.wPin : (v.wA && !v.wB);
    reqValid = 1'b1; reqWrite = v.wr; reqWord = v.word; reqFetch = v.fetch;
    reqAddr = v.addr; reqWdata = v.wdata; readyIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 60 && !gotDone; c++) begin
      isStb  = !rdN || !wrLowN || (!v.sMode && !wrHighN);
      isAddr = v.adv ? (!aleAdv && !isStb) : aleAdv;
      if (!reqReady) busy = 1'b1;
      if (fetchOut) fetchSeen = 1'b1;
      if (isAddr) begin
        if (nCyc == 0) begin
          addr1 = busAdOut;
          bhe1  = !wrHighN;
        end
        nCyc++;
        lat  = busAdOut;
        stbK = 0;
      end
      if (isStb) begin
        stb++;
        stbK++;
        if (!wrLowN) wl++;
        if (!v.sMode && !wrHighN) wh++;
        if (firstStb) wd1 = busAdOut;
        firstStb = 1'b0;
        readyIn = (stbK > int'(v.rdyLow));
      end else begin
        readyIn = 1'b1;
      end
      if (done) begin
        gotDone = 1'b1;
        rd = rdData;
      end else begin
        @(negedge clk);
      end
    end
    chk($sformatf("vec %0d R11 completion", idx), {15'd0, gotDone}, 16'd1);
    chk($sformatf("vec %0d R11 busy while cycling", idx), {15'd0, busy}, 16'd1);
    chk($sformatf("vec %0d R1 R3 byte cycles", idx), 16'(nCyc), {14'd0, v.eCyc});
    chk($sformatf("vec %0d R7 address phase", idx), addr1, v.eAddr);
    chk($sformatf("vec %0d R4 R6 high enable", idx), {15'd0, bhe1}, {15'd0, v.eBhe});
    chk($sformatf("vec %0d R5 wrLow cycles", idx), 16'(wl), {14'd0, v.eWl});
    chk($sformatf("vec %0d R5 wrHigh cycles", idx), 16'(wh), {14'd0, v.eWh});
    chk($sformatf("vec %0d R9 strobe length", idx), 16'(stb), {12'd0, v.eStb});
    chk($sformatf("vec %0d R10 fetch indicator", idx), {15'd0, fetchSeen}, {15'd0, v.eFetch});
    if (v.wr) chk($sformatf("vec %0d R3 write data", idx), wd1, v.eWd);
    else      chk($sformatf("vec %0d R11 read data", idx), rd, v.eRd);
    @(negedge clk);
    if (v.adv) chk($sformatf("vec %0d R8 idle level", idx), {15'd0, aleAdv}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state R11 R7
    chk("reset R11 reqReady", {15'd0, reqReady}, 16'd1);
    chk("reset R11 done", {15'd0, done}, 16'd0);
    chk("reset R7 rdN", {15'd0, rdN}, 16'd1);
    chk("reset R7 aleAdv", {15'd0, aleAdv}, 16'd0);
    chk("reset R7 busAdOe", {15'd0, busAdOe}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("after reset R11 reqReady", {15'd0, reqReady}, 16'd1);
    for (int i = 0; i < NV; i++) runVec(i, VECS[i]);
    // R2 flag for each policy
    cfgWidthA = 1'b0; cfgWidthB = 1'b0; #1;
    chk("R2 illegal policy flag", {15'd0, cfgError}, 16'd1);
    cfgWidthA = 1'b1; cfgWidthB = 1'b0; #1;
    chk("R2 fixed 16 flag", {15'd0, cfgError}, 16'd0);
    cfgWidthA = 1'b1; cfgWidthB = 1'b1; #1;
    chk("R2 pin policy flag", {15'd0, cfgError}, 16'd0);
    // R8 address-valid idle level, R7 latch-pulse idle level
    cfgAdvMode = 1'b1; #1;
    chk("R8 idle address-valid high", {15'd0, aleAdv}, 16'd1);
    cfgAdvMode = 1'b0; #1;
    chk("R7 idle latch low", {15'd0, aleAdv}, 16'd0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11: got no completion, expected run to end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule